// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block is the only path between a 32-bit core and a data memory organised as 32-bit words. Every memory operation is an explicit load or store of a byte, a halfword or a word. For a store, the block turns the byte address into a word address, copies the store data into every lane the access could use, and asserts the byte enables only for the lanes it covers. For a load, it reads the addressed lanes from the returned word and sign-extends or zero-extends the value to 32 bits. Lane mapping depends on a byte-order input that can change from one access to the next. In big-endian order the most significant byte of a word is at the lowest byte address. In little-endian order the least significant byte is there.

An access the block cannot perform is never sent to memory. This covers a word address that is not a multiple of 4, a halfword address that is odd, and the reserved size code. The block drops the memory request for such an access and reports a fault instead. Memory is assumed to return read data one cycle after an enabled read. Results and faults are registered, so both appear two cycles after the request, and a new request may be issued every cycle.

A small response state machine tracks what the previous cycle's request left in flight. Its states are `ST_IDLE` (nothing to report), `ST_LOAD` (an aligned load whose read data is arriving) and `ST_FAULT` (a misaligned access to report). The request in the current cycle selects the next state, whatever the present state is. The transitions are ACCEPT_LOAD, taken to `ST_LOAD` on a valid aligned load. RAISE_FAULT is taken to `ST_FAULT` on any valid misaligned access. SETTLE is taken to `ST_IDLE` on an aligned store or an idle cycle.

Top module: `lsu_lane_align`

## Requirements
- R1: In the cycle of a valid aligned request, `mem_addr` equals `req_addr` shifted right by two, `mem_en` is 1, and `mem_we` equals `req_write`.
- R2: Size codes are 00 byte, 01 halfword, 10 word and 11 reserved. A word access with `req_addr[1:0]` not 00 is misaligned. A halfword access with `req_addr[0]` = 1 is misaligned. Size 11 is always misaligned. A byte access is never misaligned.
- R3: For a misaligned request, `mem_en`, `mem_we` and `mem_be` are all 0 in that cycle. Two clock edges later, `fault` is 1 for one cycle and `ld_data` is 0.
- R4: Byte enable bit k covers `mem_wdata`/`mem_rdata` bits 8k+7..8k. With `big_endian` = 0, byte address offset o uses lane o. With `big_endian` = 1, it uses lane 3-o. A byte access enables one lane, a halfword access enables the two lanes of its offsets o and o+1, and a word access enables all four lanes.
- R5: For an aligned store, `mem_wdata` is four copies of `req_wdata[7:0]` for a byte, two copies of `req_wdata[15:0]` for a halfword, and `req_wdata` for a word, in either byte order.
- R6: A load value is assembled from bytes in address order. In big-endian order the byte at the lower address is the more significant one. In little-endian order it is the less significant one. A word load returns the read word unchanged.
- R7: With `req_signed` = 1, byte and halfword load values are sign-extended to 32 bits.
- R8: With `req_signed` = 0, byte and halfword load values are zero-extended to 32 bits.
- R9: Every load, aligned or not, gives `ld_valid` = 1 with its result two clock edges after its request. Loads issued on consecutive cycles give results on consecutive cycles. A store never raises `ld_valid`.
- R10: After reset, `ld_valid`, `fault` and `ld_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Sign-extend partial-word loads |
| big_endian | input | 1 | 1 = big-endian lane mapping |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_rdata | input | 32 | Read word, valid one cycle after an enabled read |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_be | output | 4 | Byte enables, bit k for lane k |
| mem_wdata | output | 32 | Lane-replicated store data |
| ld_valid | output | 1 | Load response valid |
| ld_data | output | 32 | Extended load result |
| fault | output | 1 | Misaligned access reported |

## Verification
The bench builds the block with `ADDR_W` = 12, so the word address is 10 bits wide and the word at the top of the address space can be reached directly. The bench sweeps every combination of byte order, all four size codes, all four low address offsets, signedness and load/store, at three word addresses. Its memory model returns a different word for each address, so both sign polarities and every lane position are covered. A separate run issues loads and faulting accesses back to back to check the two-cycle pipeline with no gaps between requests.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;
    localparam int DATA_W     = 32;
    localparam int LANE_W     = 8;
    localparam int WORD_BYTES = DATA_W / LANE_W;
    localparam int OFS_W      = $clog2(WORD_BYTES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_FAULT = 2'b10
    } resp_state_e;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        acc_size_e        size;
        logic             sgn;
        logic             big;
        logic             is_load;
    } acc_ctl_t;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lsalign_pkg::*;
(
    input  logic [OFS_W-1:0]      ofs,
    input  acc_size_e             size,
    input  logic                  big,
    output logic [WORD_BYTES-1:0] be,
    output logic                  misalign
);
    localparam int POS_W = OFS_W + 1;

    logic [POS_W-1:0]      span;
    logic [POS_W-1:0]      lo;
    logic [WORD_BYTES-1:0] raw_be;

    always_comb begin
        unique case (size)
            SZ_BYTE: span = POS_W'(1);
            SZ_HALF: span = POS_W'(2);
            SZ_WORD: span = POS_W'(WORD_BYTES);
            default: span = '0;
        endcase
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = ofs[0];
            SZ_WORD: misalign = (ofs != '0);
            default: misalign = 1'b1;
        endcase
    end

    assign lo = {1'b0, ofs};

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        localparam logic [POS_W-1:0] LE_POS = POS_W'(l);
        localparam logic [POS_W-1:0] BE_POS = POS_W'(WORD_BYTES - 1 - l);
        logic [POS_W-1:0] pos;
        assign pos       = big ? BE_POS : LE_POS;
        assign raw_be[l] = (pos >= lo) && (pos < (lo + span));
    end

    assign be = misalign ? '0 : raw_be;
endmodule

// File: rtl/store_steer.sv
module store_steer
    import lsalign_pkg::*;
(
    input  acc_size_e         size,
    input  logic [DATA_W-1:0] sdata,
    output logic [DATA_W-1:0] wdata
);
    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata[l*LANE_W +: LANE_W] = sdata[LANE_W-1:0];
                SZ_HALF: wdata[l*LANE_W +: LANE_W] = sdata[(l % 2)*LANE_W +: LANE_W];
                default: wdata[l*LANE_W +: LANE_W] = sdata[l*LANE_W +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/load_extract.sv
module load_extract
    import lsalign_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  acc_ctl_t          ctl,
    output logic [DATA_W-1:0] result
);
    localparam int HALF_W = 2 * LANE_W;

    logic [OFS_W-1:0]  byte_lane;
    logic [OFS_W-1:0]  half_lane;
    logic [LANE_W-1:0] bval;
    logic [HALF_W-1:0] hval;

    assign byte_lane = ctl.big ? OFS_W'(WORD_BYTES - 1) - ctl.ofs : ctl.ofs;
    assign half_lane = ctl.big ? OFS_W'(WORD_BYTES - 2) - ctl.ofs : ctl.ofs;
    assign bval      = rdata[{byte_lane, 3'b000} +: LANE_W];
    assign hval      = rdata[{half_lane, 3'b000} +: HALF_W];

    always_comb begin
        unique case (ctl.size)
            SZ_BYTE: result = {{(DATA_W-LANE_W){ctl.sgn & bval[LANE_W-1]}}, bval};
            SZ_HALF: result = {{(DATA_W-HALF_W){ctl.sgn & hval[HALF_W-1]}}, hval};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsalign_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic                  req_signed,
    input  logic                  big_endian,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [ADDR_W-3:0]     mem_addr,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [WORD_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  ld_valid,
    output logic [DATA_W-1:0]     ld_data,
    output logic                  fault
);
    acc_size_e             size_e;
    logic [WORD_BYTES-1:0] lane_be;
    logic                  misalign;
    logic [DATA_W-1:0]     load_val;

    resp_state_e state_q, state_d;
    acc_ctl_t    ctl_q, ctl_d;
    logic              ld_valid_d, fault_d;
    logic [DATA_W-1:0] ld_data_d;

    assign size_e = acc_size_e'(req_size);

    lane_decode u_decode (
        .ofs      (req_addr[OFS_W-1:0]),
        .size     (size_e),
        .big      (big_endian),
        .be       (lane_be),
        .misalign (misalign)
    );

    store_steer u_steer (
        .size  (size_e),
        .sdata (req_wdata),
        .wdata (mem_wdata)
    );

    load_extract u_extract (
        .rdata  (mem_rdata),
        .ctl    (ctl_q),
        .result (load_val)
    );

    // request side: combinational towards memory
    assign mem_addr = req_addr[ADDR_W-1:OFS_W];
    assign mem_en   = req_valid && !misalign;
    assign mem_we   = mem_en && req_write;
    assign mem_be   = req_valid ? lane_be : '0;

    // next-state: ACCEPT_LOAD, RAISE_FAULT, SETTLE
    always_comb begin
        if (req_valid && misalign)
            state_d = ST_FAULT;
        else if (req_valid && !req_write)
            state_d = ST_LOAD;
        else
            state_d = ST_IDLE;
        ctl_d = '{ofs: req_addr[OFS_W-1:0], size: size_e, sgn: req_signed,
                  big: big_endian, is_load: !req_write};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_d;
        end
    end

    // response outputs by state
    always_comb begin
        ld_valid_d = 1'b0;
        fault_d    = 1'b0;
        ld_data_d  = ld_data;
        unique case (state_q)
            ST_LOAD: begin
                ld_valid_d = 1'b1;
                ld_data_d  = load_val;
            end
            ST_FAULT: begin
                ld_valid_d = ctl_q.is_load;
                fault_d    = 1'b1;
                ld_data_d  = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            fault    <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= ld_valid_d;
            fault    <= fault_d;
            ld_data  <= ld_data_d;
        end
    end

    AST_BYTE_ALWAYS_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |-> mem_en); // R2

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |-> ($countones(mem_be) == 1)); // R4

    AST_ODD_HALF_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01 && req_addr[0]) |-> ##2 (fault && ld_data == '0)); // R3

    AST_FAULT_CLEARS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (ld_data == '0)); // R3

    AST_LOAD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> ##2 ld_valid); // R9

    AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> ##2 !ld_valid); // R9

    AST_UNSIGNED_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_signed && req_size == 2'b00)
            |-> ##2 (ld_data[DATA_W-1:LANE_W] == '0)); // R8
endmodule

// File: tb/tb_lsu_lane_align.sv
`timescale 1ns/1ps
module tb_lsu_lane_align;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, big_endian = 1'b0;
    logic [1:0]    req_size = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   mem_rdata = '0;
    logic [AW-3:0] mem_addr;
    logic          mem_en, mem_we, ld_valid, fault;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata, ld_data;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lsu_lane_align #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .big_endian(big_endian),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .ld_valid(ld_valid), .ld_data(ld_data), .fault(fault)
    );

    function automatic logic [31:0] word_at(input logic [AW-3:0] wa);
        logic [31:0] v;
        v = (32'(wa) + 32'd1) * 32'h9E37_79B1;
        if (wa[0]) v = v ^ 32'h8080_8080;
        return v;
    endfunction

    // memory model: read data one cycle after an enabled read
    always @(posedge clk) mem_rdata <= (mem_en && !mem_we) ? word_at(mem_addr) : 32'h0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_mis(input logic [1:0] sz, input logic [1:0] o);
        return (sz == 2'b11) || (sz == 2'b01 && o[0]) || (sz == 2'b10 && o != 2'b00);
    endfunction

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] o, input bit e);
        logic [3:0] b = '0;
        int nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        if (is_mis(sz, o)) return 4'b0;
        for (int k = 0; k < nb; k++) begin
            int a = int'(o) + k;
            b[e ? 3 - a : a] = 1'b1;
        end
        return b;
    endfunction

    function automatic logic [7:0] byte_at(input logic [31:0] w, input int a, input bit e);
        return e ? w[8*(3-a) +: 8] : w[8*a +: 8];
    endfunction

    function automatic logic [31:0] exp_load(input logic [AW-1:0] ad, input logic [1:0] sz,
                                             input bit sg, input bit e);
        logic [31:0] w = word_at(ad[AW-1:2]);
        int o = int'(ad[1:0]);
        logic [15:0] h;
        logic [7:0]  b;
        if (sz == 2'b00) begin
            b = byte_at(w, o, e);
            return sg ? {{24{b[7]}}, b} : {24'h0, b};
        end else if (sz == 2'b01) begin
            h = e ? {byte_at(w, o, e), byte_at(w, o + 1, e)}
                  : {byte_at(w, o + 1, e), byte_at(w, o, e)};
            return sg ? {{16{h[15]}}, h} : {16'h0, h};
        end
        return w;
    endfunction

    task automatic access(input bit wr, input logic [1:0] sz, input logic [AW-1:0] ad,
                          input bit sg, input bit e, input logic [31:0] sd);
        bit mis = is_mis(sz, ad[1:0]);
        logic [31:0] ewd;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = ad;
        req_signed = sg; big_endian = e; req_wdata = sd;
        #1;
        chk("R1 mem_addr", 32'(mem_addr), 32'(ad >> 2));
        chk(mis ? "R3 mem_en" : "R1 mem_en", 32'(mem_en), 32'(!mis));
        chk(mis ? "R3 mem_we" : "R1 mem_we", 32'(mem_we), 32'(wr && !mis));
        chk(mis ? "R3 mem_be" : "R4 mem_be", 32'(mem_be), 32'(exp_be(sz, ad[1:0], e)));
        if (wr && !mis) begin
            ewd = (sz == 2'b00) ? {4{sd[7:0]}} : (sz == 2'b01) ? {2{sd[15:0]}} : sd;
            chk("R5 mem_wdata", mem_wdata, ewd);
        end
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 fault", 32'(fault), 32'(mis));
        chk("R9 ld_valid", 32'(ld_valid), 32'(!wr));
        if (mis)
            chk("R3 ld_data zero", ld_data, 32'h0);
        else if (!wr)
            chk(sz == 2'b10 ? "R6 word load" : (sg ? "R7 signed load" : "R8 unsigned load"),
                ld_data, exp_load(ad, sz, sg, e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] bases [3];
        logic [AW-1:0] pa [4];
        logic [1:0]    ps [4];
        bases[0] = 12'h000; bases[1] = 12'h004; bases[2] = 12'hFFC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 ld_valid", 32'(ld_valid), 32'h0);
        chk("R10 fault", 32'(fault), 32'h0);
        chk("R10 ld_data", ld_data, 32'h0);
        rst_n = 1'b1;

        for (int bi = 0; bi < 3; bi++)
            for (int e = 0; e < 2; e++)
                for (int sz = 0; sz < 4; sz++)
                    for (int o = 0; o < 4; o++)
                        for (int sg = 0; sg < 2; sg++)
                            for (int wr = 0; wr < 2; wr++)
                                access(wr[0], sz[1:0], bases[bi] + AW'(o), sg[0], e[0],
                                       32'hF1E2_D3C4 ^ (32'(o) << 8) ^ 32'(bi * 7));

        // back-to-back loads, with a faulting one in the middle (R9)
        pa[0] = 12'h102; ps[0] = 2'b00;
        pa[1] = 12'h0A2; ps[1] = 2'b01;
        pa[2] = 12'h0A3; ps[2] = 2'b01;
        pa[3] = 12'h200; ps[3] = 2'b10;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i < 4) begin
                req_valid = 1'b1; req_write = 1'b0; req_size = ps[i]; req_addr = pa[i];
                req_signed = 1'b1; big_endian = i[0];
            end else begin
                req_valid = 1'b0;
            end
            #1;
            if (i >= 2) begin
                chk("R9 back-to-back ld_valid", 32'(ld_valid), 32'h1);
                chk("R9 back-to-back fault", 32'(fault), 32'(is_mis(ps[i-2], pa[i-2][1:0])));
                chk("R9 back-to-back ld_data", ld_data,
                    is_mis(ps[i-2], pa[i-2][1:0]) ? 32'h0
                        : exp_load(pa[i-2], ps[i-2], 1'b1, (i - 2) % 2 == 1));
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule